// File: doc/BRIEF.md
# Interrupt and Power Control Register Block

This block sits in the I/O space of a secondary processor and holds the registers that gate its interrupt line and put it to sleep. It stores a one-bit master interrupt enable, a 32-bit interrupt enable mask, a 32-bit pending-request latch, a boot-status flag and a power mode. A simple bus port carries a valid strobe, a write strobe, a size code, a full address and 32 bits of data. Each register accepts only certain access sizes. An access of the wrong size, or to an address that is not mapped, reads as zero and changes nothing.

Request bits are set by one-cycle pulses on the source inputs. Software clears them by writing ones. The CPU interrupt output is the master enable ANDed with "any enabled request pending". A write to the power byte can park the processor in halt. It leaves halt by itself as soon as an enabled request is pending, whatever the master enable holds. Power encodings that the block does not perform are refused with a one-cycle error pulse.

Top module: `irq_pwr_regs`

## Requirements
- R1: After reset the master enable, enable mask, request latch, boot flag, read data, cpu_irq, halt and pwr_err are all zero, and the power mode is execute.
- R2: At BASE+0x208, writes of byte, halfword or word size (size codes 0, 1, 2) store data bit 0 as the master enable. A read of any of these sizes returns the master enable in bit 0 with zeros above it.
- R3: At BASE+0x210 the enable mask is read and written only as a word (size code 2). A byte or halfword write there is ignored, and a byte or halfword read returns zero.
- R4: At BASE+0x214 a word read returns the request latch. A word write clears each latch bit whose data bit is 1 and keeps the others. A non-word access there neither reads nor changes the latch.
- R5: A pulse on src_pulse[i] sets request bit i at the next clock edge. A pulse and a clearing write to the same bit in the same cycle leave the bit set.
- R6: cpu_irq is high exactly when the master enable is 1 and the enable mask ANDed with the request latch is nonzero.
- R7: At BASE+0x300 the boot flag is read and written as a byte (size code 0) using data bit 0, where 0 means booting and 1 means done. Other sizes read zero and are ignored on write.
- R8: A byte write to BASE+0x301 decodes data bits 7:6. Code 00 selects execute (halt low) and code 10 selects halt (halt high from the next cycle).
- R9: Power codes 01 and 11 leave the power mode unchanged and raise pwr_err for exactly the one cycle after the write.
- R10: While halted, halt drops at the first clock edge at which the enable mask ANDed with the request latch is nonzero, even when the master enable is 0.
- R11: A read of an unmapped address (including BASE+0x301) or with size code 3 returns zero. Such writes change no register.
- R12: bus_rdata carries the read value in the cycle after a valid read and is zero in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_vld | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Registered read data |
| src_pulse | input | NSRC | Interrupt source pulses |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| halt | output | 1 | High while in halt mode |
| pwr_err | output | 1 | One-cycle pulse on a refused power code |

## Verification
Every result in this block lands one clock edge after its cause. Read data, the power mode, the error pulse and request bits each appear at the first edge after their stimulus. cpu_irq follows the latched registers with no further delay, so it moves together with the register that changed it. Wake-up takes two edges from a source pulse: one to latch the request and one to clear halt. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It compares all four outputs on every falling edge, so each result is checked in exactly the cycle it is due. Directed reads add value checks on the registers.

// File: rtl/irq_pwr_regs.sv
module irq_pwr_regs #(
  parameter logic [31:0] BASE = 32'h0400_0000,
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_vld,
  input  logic            bus_wr,
  input  logic [1:0]      bus_size,
  input  logic [31:0]     bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NSRC-1:0] src_pulse,
  output logic            cpu_irq,
  output logic            halt,
  output logic            pwr_err
);
  localparam int DW = 32;
  localparam logic [31:0] A_MEN  = BASE + 32'h208;
  localparam logic [31:0] A_IEN  = BASE + 32'h210;
  localparam logic [31:0] A_REQ  = BASE + 32'h214;
  localparam logic [31:0] A_BOOT = BASE + 32'h300;
  localparam logic [31:0] A_PWR  = BASE + 32'h301;
  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_W = 2'd2;
  localparam logic [1:0] PM_RUN  = 2'b00;
  localparam logic [1:0] PM_HALT = 2'b10;

  logic          men_q, boot_q, halt_q, err_q;
  logic [DW-1:0] ien_q, req_q, src_w, rd_d, rdata_q;

  wire wr_en = bus_vld & bus_wr;
  wire rd_en = bus_vld & ~bus_wr;
  wire sz_ok = bus_size != 2'b11;

  wire hit_men  = (bus_addr == A_MEN)  & sz_ok;
  wire hit_ien  = (bus_addr == A_IEN)  & (bus_size == SZ_W);
  wire hit_req  = (bus_addr == A_REQ)  & (bus_size == SZ_W);
  wire hit_boot = (bus_addr == A_BOOT) & (bus_size == SZ_B);
  wire hit_pwr  = (bus_addr == A_PWR)  & (bus_size == SZ_B);

  wire [1:0] pm_code = bus_wdata[7:6];
  wire       pwr_wr  = wr_en & hit_pwr;
  wire       pending = |(ien_q & req_q);
  wire [DW-1:0] req_clr = (wr_en & hit_req) ? bus_wdata : '0;

  always_comb begin
    src_w = '0;
    src_w[NSRC-1:0] = src_pulse;
  end

  always_comb begin
    rd_d = '0;
    if (hit_men)       rd_d = {{(DW-1){1'b0}}, men_q};
    else if (hit_ien)  rd_d = ien_q;
    else if (hit_req)  rd_d = req_q;
    else if (hit_boot) rd_d = {{(DW-1){1'b0}}, boot_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      men_q   <= 1'b0;
      ien_q   <= '0;
      req_q   <= '0;
      boot_q  <= 1'b0;
      halt_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rdata_q <= rd_en ? rd_d : '0;
      req_q   <= (req_q & ~req_clr) | src_w;
      if (wr_en & hit_men)  men_q  <= bus_wdata[0];
      if (wr_en & hit_ien)  ien_q  <= bus_wdata;
      if (wr_en & hit_boot) boot_q <= bus_wdata[0];
      err_q <= pwr_wr & (pm_code != PM_RUN) & (pm_code != PM_HALT);
      if (halt_q & pending)                  halt_q <= 1'b0;
      else if (pwr_wr & (pm_code == PM_HALT)) halt_q <= 1'b1;
      else if (pwr_wr & (pm_code == PM_RUN))  halt_q <= 1'b0;
    end
  end

  assign bus_rdata = rdata_q;
  assign cpu_irq   = men_q & pending;
  assign halt      = halt_q;
  assign pwr_err   = err_q;
endmodule

module irq_pwr_regs_chk #(
  parameter logic [31:0] BASE = 32'h0400_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_vld,
  input logic        bus_wr,
  input logic [1:0]  bus_size,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        cpu_irq,
  input logic        halt,
  input logic        pwr_err
);
  wire pwr_byte_wr = bus_vld & bus_wr & (bus_size == 2'd0) & (bus_addr == BASE + 32'h301);
  wire any_rd      = bus_vld & ~bus_wr;
  wire unmapped    = (bus_addr != BASE + 32'h208) & (bus_addr != BASE + 32'h210) &
                     (bus_addr != BASE + 32'h214) & (bus_addr != BASE + 32'h300);

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_err |-> $past(pwr_byte_wr & bus_wdata[6]));

  // R8
  halt_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_byte_wr & (bus_wdata[7:6] == 2'b10) & !halt) |=> halt);

  // R10
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt & cpu_irq) |=> !halt);

  // R11
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_rd & (unmapped | (bus_size == 2'd3))) |=> (bus_rdata == 32'd0));

  // R12
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_rd |=> (bus_rdata == 32'd0));
endmodule

bind irq_pwr_regs irq_pwr_regs_chk #(.BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
  .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .halt(halt), .pwr_err(pwr_err)
);

// File: tb/tb_irq_pwr_regs.sv
module tb_irq_pwr_regs;
  localparam logic [31:0] BASE = 32'h0400_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_vld = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_size = 2'd0;
  logic [31:0] bus_addr = 32'd0, bus_wdata = 32'd0;
  logic [31:0] src_pulse = 32'd0;
  logic [31:0] bus_rdata;
  logic        cpu_irq, halt, pwr_err;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irq_pwr_regs #(.BASE(BASE), .NSRC(32)) dut (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_pulse(src_pulse), .cpu_irq(cpu_irq),
    .halt(halt), .pwr_err(pwr_err)
  );

  // behavioural reference
  bit          m_en, m_boot, m_halt, m_err;
  bit [31:0]   m_mask, m_req, m_rd;

  function automatic bit [31:0] m_read(bit [31:0] off, bit [1:0] sz);
    case (off)
      32'h208: return (sz == 2'd3) ? 32'd0 : {31'd0, m_en};
      32'h210: return (sz == 2'd2) ? m_mask : 32'd0;
      32'h214: return (sz == 2'd2) ? m_req : 32'd0;
      32'h300: return (sz == 2'd0) ? {31'd0, m_boot} : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit [31:0] off;
    bit        was_pending;
    bit [31:0] clr;
    off = bus_addr - BASE;
    if (!rst_n) begin
      m_en = 0; m_boot = 0; m_halt = 0; m_err = 0; m_mask = 0; m_req = 0; m_rd = 0;
    end else begin
      was_pending = (m_mask & m_req) != 0;
      m_rd  = (bus_vld && !bus_wr) ? m_read(off, bus_size) : 32'd0;
      m_err = 0;
      clr   = 0;
      if (m_halt && was_pending) m_halt = 0;
      else if (bus_vld && bus_wr && off == 32'h301 && bus_size == 2'd0) begin
        if (bus_wdata[7:6] == 2'b10) m_halt = 1;
        else if (bus_wdata[7:6] == 2'b00) m_halt = 0;
      end
      if (bus_vld && bus_wr && off == 32'h301 && bus_size == 2'd0 && bus_wdata[6]) m_err = 1;
      if (bus_vld && bus_wr) begin
        if (off == 32'h208 && bus_size != 2'd3) m_en = bus_wdata[0];
        if (off == 32'h210 && bus_size == 2'd2) m_mask = bus_wdata;
        if (off == 32'h214 && bus_size == 2'd2) clr = bus_wdata;
        if (off == 32'h300 && bus_size == 2'd0) m_boot = bus_wdata[0];
      end
      m_req = (m_req & ~clr) | src_pulse;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R12 rdata vs model", bus_rdata, m_rd);
      check("R6 cpu_irq vs model", {31'd0, cpu_irq}, {31'd0, m_en && ((m_mask & m_req) != 0)});
      check("R8 halt vs model", {31'd0, halt}, {31'd0, m_halt});
      check("R9 pwr_err vs model", {31'd0, pwr_err}, {31'd0, m_err});
    end
  end

  task automatic wr(logic [11:0] off, logic [1:0] sz, logic [31:0] d);
    @(negedge clk);
    bus_vld = 1; bus_wr = 1; bus_size = sz; bus_addr = BASE + {20'd0, off}; bus_wdata = d;
    @(negedge clk);
    bus_vld = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [11:0] off, logic [1:0] sz, output logic [31:0] q);
    @(negedge clk);
    bus_vld = 1; bus_wr = 0; bus_size = sz; bus_addr = BASE + {20'd0, off};
    @(negedge clk);
    q = bus_rdata;
    bus_vld = 0;
  endtask

  task automatic pulse(logic [31:0] s);
    @(negedge clk);
    src_pulse = s;
    @(negedge clk);
    src_pulse = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 rdata", bus_rdata, 0);
    check("R1 cpu_irq", {31'd0, cpu_irq}, 0);
    check("R1 halt", {31'd0, halt}, 0);
    check("R1 pwr_err", {31'd0, pwr_err}, 0);
    rd(12'h210, 2'd2, q); check("R1 mask", q, 0);
    rd(12'h214, 2'd2, q); check("R1 req", q, 0);
    rd(12'h300, 2'd0, q); check("R1 boot", q, 0);
    rd(12'h208, 2'd2, q); check("R1 enable", q, 0);

    // R2
    wr(12'h208, 2'd0, 32'h0000_00FF); rd(12'h208, 2'd2, q); check("R2 byte write", q, 1);
    wr(12'h208, 2'd1, 32'h0000_0002); rd(12'h208, 2'd0, q); check("R2 half write", q, 0);
    wr(12'h208, 2'd2, 32'hFFFF_FFFF); rd(12'h208, 2'd1, q); check("R2 word write", q, 1);

    // R3
    wr(12'h210, 2'd2, 32'h0000_00F0); rd(12'h210, 2'd2, q); check("R3 word", q, 32'hF0);
    wr(12'h210, 2'd1, 32'h0000_FFFF); rd(12'h210, 2'd2, q); check("R3 half write ignored", q, 32'hF0);
    rd(12'h210, 2'd1, q); check("R3 half read", q, 0);

    // R5 and R6
    pulse(32'h0000_0012);
    rd(12'h214, 2'd2, q); check("R5 set", q, 32'h12);
    check("R6 irq high", {31'd0, cpu_irq}, 1);
    // R4
    wr(12'h214, 2'd2, 32'h0000_0010); rd(12'h214, 2'd2, q); check("R4 w1c", q, 32'h02);
    check("R6 irq low", {31'd0, cpu_irq}, 0);
    @(negedge clk);
    bus_vld = 1; bus_wr = 1; bus_size = 2'd2; bus_addr = BASE + 32'h214; bus_wdata = 32'h4;
    src_pulse = 32'h4;
    @(negedge clk);
    bus_vld = 0; bus_wr = 0; src_pulse = 0;
    rd(12'h214, 2'd2, q); check("R5 set wins", q, 32'h06);
    wr(12'h214, 2'd0, 32'h0000_00FF); rd(12'h214, 2'd2, q); check("R4 byte ignored", q, 32'h06);
    rd(12'h214, 2'd0, q); check("R4 byte read", q, 0);
    wr(12'h214, 2'd2, 32'hFFFF_FFFF); rd(12'h214, 2'd2, q); check("R4 clear all", q, 0);

    // R7
    wr(12'h300, 2'd0, 32'h0000_0001); rd(12'h300, 2'd0, q); check("R7 byte", q, 1);
    rd(12'h300, 2'd2, q); check("R7 word read", q, 0);
    wr(12'h300, 2'd2, 32'h0); rd(12'h300, 2'd0, q); check("R7 word write ignored", q, 1);

    // R8 and R9
    wr(12'h301, 2'd0, 32'h0000_0080); check("R8 enter halt", {31'd0, halt}, 1);
    wr(12'h301, 2'd0, 32'h0000_0040); check("R9 err pulse", {31'd0, pwr_err}, 1);
    check("R9 mode kept", {31'd0, halt}, 1);
    @(negedge clk); check("R9 one cycle", {31'd0, pwr_err}, 0);
    wr(12'h301, 2'd0, 32'h0000_00C0); check("R9 sleep refused", {31'd0, pwr_err}, 1);
    wr(12'h301, 2'd0, 32'h0000_0000); check("R8 execute", {31'd0, halt}, 0);

    // R10
    wr(12'h208, 2'd2, 32'h0);
    wr(12'h301, 2'd0, 32'h0000_0080);
    pulse(32'h0000_0020);
    check("R10 still halted", {31'd0, halt}, 1);
    @(negedge clk);
    check("R10 woke", {31'd0, halt}, 0);
    check("R10 no irq", {31'd0, cpu_irq}, 0);
    wr(12'h214, 2'd2, 32'hFFFF_FFFF);

    // R11
    rd(12'h204, 2'd2, q); check("R11 unmapped read", q, 0);
    rd(12'h301, 2'd0, q); check("R11 power read", q, 0);
    wr(12'h20C, 2'd2, 32'hFFFF_FFFF); rd(12'h210, 2'd2, q); check("R11 unmapped write", q, 32'hF0);
    wr(12'h208, 2'd3, 32'h1); rd(12'h208, 2'd2, q); check("R11 size3 write", q, 0);
    rd(12'h210, 2'd3, q); check("R11 size3 read", q, 0);

    // R12
    rd(12'h210, 2'd2, q); check("R12 data due", q, 32'hF0);
    @(negedge clk); check("R12 zero after", bus_rdata, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule